// File: doc/BRIEF.md
# Systolic 4x4 SAD Array

This block computes the sum of absolute differences (SAD) between one 4x4 current block and a series of vertically displaced 4x4 candidates taken from a reference window. It is a linear chain of four processing elements. Each element works on a whole row of four 8-bit pixels at once. PE k keeps current-block row k in a local register, so the current block is written once and then reused for the whole search. Reference rows arrive one per accepted cycle and each is presented a single time. Partial sums travel from one PE to the next, one register per hop. Once the chain has filled, a finished SAD leaves the last PE on every accepted row.

To use the block, software first writes the four current rows with `load_x`. Every write also starts a new search. Reference rows are then presented in order, top row first, with `y_valid`. The fourth accepted row completes displacement 0, and each accepted row after it completes the next displacement. Each result is marked with its displacement so that a downstream minimum finder can keep track of the best candidate. The pipeline advances only on accepted rows, so gaps in the reference stream are allowed.

Top module: `sad_systolic_4x4`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `sad_valid` is 0 and `sad_out` is 0.
- R2: A cycle with `load_x` high writes `x_row` into current-block row `x_sel`. Pixel j of a row sits at bits [8j+7:8j]. Rows that are not written keep their values across later searches.
- R3: The result for displacement m equals the sum over i,j in 0..3 of |x(i,j) - y(i+m,j)|. Here y(r,·) is the r-th reference row accepted since the last `load_x` cycle, counting from 0.
- R4: `sad_valid` goes high in the cycle right after the edge that accepts reference row m+3, with `sad_m` = m. Displacements come out in increasing order 0,1,2,3.
- R5: Reference rows accepted after row 6 of a search produce no output.
- R6: A row is accepted only on a cycle with `y_valid` high and `load_x` low. `sad_valid` is 0 in any cycle that does not follow an accepted row.
- R7: `load_x` restarts the search count and takes priority over `y_valid`. A row presented in a load cycle is dropped, and rows accepted before the load never contribute to a later result.
- R8: The 12-bit result holds the largest SAD, 16 x 255 = 4080, without wrapping.
- R9: The first three rows of a search produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_x | input | 1 | Write a current-block row and restart the search |
| x_sel | input | 2 | Index of the current-block row being written |
| x_row | input | 32 | Current-block row data, four 8-bit pixels |
| y_valid | input | 1 | Reference row present on `y_row` |
| y_row | input | 32 | Reference row data, four 8-bit pixels |
| sad_valid | output | 1 | `sad_out` and `sad_m` hold a new result |
| sad_m | output | 2 | Vertical displacement of the result |
| sad_out | output | 12 | Sum of absolute differences |

## Verification
Some properties are checked on every cycle. A result must always follow an accepted row. Consecutive results must step the displacement by one. A load cycle is never followed by a result. Each partial sum stays within the bound for the number of rows it has covered. Other behaviour can only be shown by the scenarios, which compare against an independent model. These are the arithmetic of each SAD, the exact cycle in which it appears, the silence on the first three rows and after row 6, the reuse of stored rows after a partial reload, the dropping of a row presented in a load cycle, and the full-scale result.

// File: rtl/sad_pkg.sv
package sad_pkg;
  // Accumulator width that holds n absolute differences of pix_w bits
  function automatic int sum_w(input int pix_w, input int n);
    return pix_w + $clog2(n);
  endfunction
endpackage

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int PIX_W   = 8,
  parameter int ROW_PIX = 4,
  parameter int SUM_W   = 12,
  parameter int IDX     = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     x_we,
  input  logic [PIX_W*ROW_PIX-1:0] x_in,
  input  logic                     step,
  input  logic [PIX_W*ROW_PIX-1:0] y_in,
  input  logic [SUM_W-1:0]         psum_in,
  output logic [SUM_W-1:0]         psum_out
);
  localparam int ROW_W = PIX_W * ROW_PIX;
  // Largest partial sum after IDX+1 rows have been accumulated
  localparam logic [SUM_W-1:0] BOUND =
    SUM_W'((IDX + 1) * ROW_PIX * ((1 << PIX_W) - 1));

  logic [ROW_W-1:0] x_q;
  logic [SUM_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst)       x_q <= '0;
    else if (x_we) x_q <= x_in;
  end

  always_comb begin
    acc = psum_in;
    for (int j = 0; j < ROW_PIX; j++) begin
      logic [PIX_W-1:0] a, b;
      a = x_q[j*PIX_W +: PIX_W];
      b = y_in[j*PIX_W +: PIX_W];
      acc = acc + SUM_W'((a > b) ? (a - b) : (b - a));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       psum_out <= '0;
    else if (step) psum_out <= acc;
  end

  // R8: partial sum never exceeds its row-count bound
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    psum_out <= BOUND);
endmodule

// File: rtl/sad_seq.sv
module sad_seq #(
  parameter int ROWS  = 4,
  parameter int NOFF  = 4,
  parameter int M_W   = 2,
  parameter int CNT_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_x,
  input  logic           y_valid,
  output logic           step,
  output logic           sad_valid,
  output logic [M_W-1:0] sad_m
);
  localparam logic [CNT_W-1:0] FIRST = CNT_W'(ROWS - 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(ROWS - 1 + NOFF);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] diff;

  assign step = y_valid && !load_x;
  assign diff = cnt - FIRST;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sad_valid <= 1'b0;
      sad_m     <= '0;
    end else if (load_x) begin
      cnt       <= '0;
      sad_valid <= 1'b0;
    end else if (y_valid) begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      sad_valid <= (cnt >= FIRST) && (cnt < LAST);
      sad_m     <= diff[M_W-1:0];
    end else begin
      sad_valid <= 1'b0;
    end
  end

  // R6: a result always follows an accepted row
  a_r6_needs_row: assert property (@(posedge clk) disable iff (rst)
    sad_valid |-> $past(step));
  // R4: consecutive results advance the displacement by one
  a_r4_m_step: assert property (@(posedge clk) disable iff (rst)
    sad_valid |=> (!sad_valid || sad_m == $past(sad_m) + 1'b1));
  // R7: a load cycle is never followed by a result
  a_r7_load_clears: assert property (@(posedge clk) disable iff (rst)
    load_x |=> !sad_valid);
endmodule

// File: rtl/sad_systolic_4x4.sv
module sad_systolic_4x4 #(
  parameter int PIX_W   = 8,
  parameter int ROW_PIX = 4,
  parameter int ROWS    = 4,
  parameter int NOFF    = 4,
  localparam int ROW_W  = PIX_W * ROW_PIX,
  localparam int SEL_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int M_W    = (NOFF > 1) ? $clog2(NOFF) : 1,
  localparam int SUM_W  = sad_pkg::sum_w(PIX_W, ROW_PIX * ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_x,
  input  logic [SEL_W-1:0] x_sel,
  input  logic [ROW_W-1:0] x_row,
  input  logic             y_valid,
  input  logic [ROW_W-1:0] y_row,
  output logic             sad_valid,
  output logic [M_W-1:0]   sad_m,
  output logic [SUM_W-1:0] sad_out
);
  localparam int CNT_W = $clog2(ROWS + NOFF);

  logic             step;
  logic [SUM_W-1:0] chain [ROWS+1];

  assign chain[0] = '0;

  sad_seq #(.ROWS(ROWS), .NOFF(NOFF), .M_W(M_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .load_x(load_x), .y_valid(y_valid),
    .step(step), .sad_valid(sad_valid), .sad_m(sad_m)
  );

  for (genvar k = 0; k < ROWS; k++) begin : g_pe
    logic we;
    assign we = load_x && (x_sel == SEL_W'(k));
    sad_pe #(.PIX_W(PIX_W), .ROW_PIX(ROW_PIX), .SUM_W(SUM_W), .IDX(k)) u_pe (
      .clk(clk), .rst(rst), .x_we(we), .x_in(x_row), .step(step),
      .y_in(y_row), .psum_in(chain[k]), .psum_out(chain[k+1])
    );
  end

  assign sad_out = chain[ROWS];
endmodule

// File: tb/sim_sad_systolic_4x4.sv
module sim_sad_systolic_4x4;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] cyc;
    logic [1:0]  m;
    logic [11:0] sad;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_x = 1'b0;
  logic [1:0]  x_sel = '0;
  logic [31:0] x_row = '0;
  logic        y_valid = 1'b0;
  logic [31:0] y_row = '0;
  logic        sad_valid;
  logic [1:0]  sad_m;
  logic [11:0] sad_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nrow   = 0;
  logic [31:0] xm [4];
  logic [31:0] rb [16];
  exp_t  exp_q [$];
  string tag_q [$];

  sad_systolic_4x4 u0 (
    .clk(clk), .rst(rst), .load_x(load_x), .x_sel(x_sel), .x_row(x_row),
    .y_valid(y_valid), .y_row(y_row), .sad_valid(sad_valid), .sad_m(sad_m),
    .sad_out(sad_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] xpat(input int s, input int k);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = 8'(s*29 + k*71 + j*13 + k*j*5);
    return r;
  endfunction

  function automatic logic [31:0] ypat(input int s, input int n);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = 8'(s*83 + n*47 + j*31 + n*j*3);
    return r;
  endfunction

  // R3: reference sum over the four stored rows and rows n-3..n
  function automatic int ref_sad(input int n);
    int s = 0;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++) begin
        int a, b;
        a = int'(xm[k][j*8 +: 8]);
        b = int'(rb[n-3+k][j*8 +: 8]);
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  task automatic tick(input bit ld, input int sel, input logic [31:0] xd,
                      input bit yv, input logic [31:0] yd, input string tag);
    exp_t e;
    load_x = ld; x_sel = sel[1:0]; x_row = xd; y_valid = yv; y_row = yd;
    if (ld) begin
      xm[sel] = xd;  // R7: load wins, search restarts
      nrow = 0;
    end else if (yv) begin
      if (nrow < 16) rb[nrow] = yd;
      if (nrow >= 3 && nrow <= 6) begin  // R9 / R5 window
        e.cyc = 32'(cyc + 1);
        e.m   = 2'(nrow - 3);
        e.sad = 12'(ref_sad(nrow));
        exp_q.push_back(e);
        tag_q.push_back(tag);
      end
      if (nrow < 16) nrow++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, '0, 1'b0, '0, "");
  endtask

  task automatic load_all(input int s);
    for (int k = 0; k < 4; k++) tick(1'b1, k, xpat(s, k), 1'b0, '0, "R2");
  endtask

  task automatic stream(input int s, input int cnt, input int gap, input string tag);
    for (int n = 0; n < cnt; n++) begin
      tick(1'b0, 0, '0, 1'b1, ypat(s, n), tag);
      idle(gap);
    end
  endtask

  // Monitor: compares every result against the scoreboard
  always @(negedge clk) begin
    if (!rst && sad_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9/R5: unexpected result m=%0d sad=%0d at cycle %0d, expected none",
                 sad_m, sad_out, cyc);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (sad_m !== e.m || sad_out !== e.sad || 32'(cyc) !== e.cyc) begin
          fails++;
          $display("FAIL %s (R3 R4): got m=%0d sad=%0d cyc=%0d, expected m=%0d sad=%0d cyc=%0d",
                   t, sad_m, sad_out, cyc, e.m, e.sad, e.cyc);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual running, expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs quiet after reset
    checks++;
    if (sad_valid !== 1'b0 || sad_out !== 12'd0) begin
      fails++;
      $display("FAIL R1: valid=%b sad=%0d, expected valid=0 sad=0", sad_valid, sad_out);
    end

    // R3 R4 R9: contiguous search
    load_all(1);
    stream(1, 7, 0, "R3 R4 R9");
    idle(3);

    // R2 R6: rewrite one row only, others reused; gaps between rows
    tick(1'b1, 2, xpat(7, 2), 1'b0, '0, "R2");
    stream(2, 7, 1, "R2 R6");
    idle(3);

    // R8: full-scale difference, expected 4080 per result
    for (int k = 0; k < 4; k++) tick(1'b1, k, 32'hFFFF_FFFF, 1'b0, '0, "R8");
    stream(0, 0, 0, "R8");
    for (int n = 0; n < 7; n++) tick(1'b0, 0, '0, 1'b1, 32'h0, "R8");
    idle(3);

    // R5: extra rows after the last displacement yield nothing
    load_all(3);
    stream(3, 10, 0, "R5");
    idle(3);

    // R7: mid-search reload and a row presented together with load_x
    load_all(4);
    stream(4, 2, 0, "R7");
    tick(1'b1, 1, xpat(4, 1), 1'b1, ypat(9, 0), "R7");
    stream(5, 7, 2, "R7");
    idle(5);

    // R5 R9: every expected result was seen and nothing remains
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5: %0d results missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule